// File: doc/BRIEF.md
# Parallel Flash Programming-Mode Controller

This block models the pin-level programming port of a small on-chip flash array that has a protection register beside it. An external programmer drives a set of mode-qualifier levels, four control-select pins, the active-low chip-enable and output-enable strobes, a digitally encoded programming-voltage level, a 16-bit address and a data byte. The block decodes these into one of seven operations: read, output disable, program, program verify, erase-all, erase verify and inhibit. It then either drives the data bus or updates the array and the security register.

Writes are edge-triggered on chip-enable, so one strobe gives one write. The flash semantics hold throughout: a program can only clear bits, and only erase-all raises them again. Several devices can share every input except the two strobes. Any device whose strobes are both high does nothing.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The programming port is qualified only while `pm_reset_i`=1, `pm_latch_i`=0 and `pm_store_i`=1. Otherwise `data_oe_o` stays 0 and no cell or security bit changes.
- R2: Read is selected by `ctl_sel_i`=4'b0000, `ce_ni`=0, `oe_ni`=0 and `vpp_lvl_i`=2'b00 (normal). It drives the byte at `addr_i` with `data_oe_o`=1. The array is indexed by the low `ARRAY_AW` address bits, so higher addresses alias, except for 0xFFFF.
- R3: Output disable is selected by `ctl_sel_i`=0, `ce_ni`=0, `oe_ni`=1 and normal level. It keeps `data_oe_o`=0 and leaves the contents unchanged.
- R4: Program is selected by `ctl_sel_i`=0, `oe_ni`=1 and `vpp_lvl_i`=2'b01 (program level) on a falling `ce_ni`. It stores the old byte AND `data_i`, so a bit is never raised.
- R5: Program verify is selected by `ctl_sel_i`=0, `ce_ni`=1, `oe_ni`=0 and program level. It drives the addressed byte.
- R6: Erase-all is selected by `ctl_sel_i`=4'b0001 (bit 0 high), `oe_ni`=1, `vpp_lvl_i`=2'b10 (erase level), `addr_i[0]`=0 and `data_i`=8'hFF on a falling `ce_ni`. It sets every cell to 8'hFF and every security bit to 1.
- R7: Erase verify is selected by `ctl_sel_i`=4'b0001, `ce_ni`=1, `oe_ni`=0 and erase level. It drives the addressed byte.
- R8: With `ce_ni`=1 and `oe_ni`=1 the device is inhibited whatever the other pins are: `data_oe_o`=0 and nothing is written.
- R9: Address 16'hFFFF maps to the security register in every operation. Programming it clears bits (AND with `data_i`), and only erase-all sets them back to 1.
- R10: Program and erase act once per falling edge of `ce_ni`, using the address and data of the clock cycle of that edge. They act only if the qualified operation holds in that cycle. Holding `ce_ni` low does not write again.
- R11: Any other pin combination is a no-op: `data_oe_o`=0 and no state changes. Examples are another `ctl_sel_i` value, vpp code 2'b11, or an erase with odd address or data other than 8'hFF.
- R12: Asserting `rst_ni` low returns every cell to 8'hFF and every security bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pm_reset_i | input | 1 | Mode qualifier: device reset level, must be 1 |
| pm_latch_i | input | 1 | Mode qualifier: address-latch level, must be 0 |
| pm_store_i | input | 1 | Mode qualifier: program-store-enable level, must be 1 |
| ctl_sel_i | input | 4 | Control-select pins; bit 0 selects erase operations |
| ce_ni | input | 1 | Chip-enable strobe, active low |
| oe_ni | input | 1 | Output-enable strobe, active low |
| vpp_lvl_i | input | 2 | Voltage level: 00 normal, 01 program, 10 erase, 11 reserved |
| addr_i | input | 16 | Byte address; 0xFFFF is the security register |
| data_i | input | 8 | Incoming data bus byte |
| data_o | output | 8 | Outgoing data bus byte, valid when data_oe_o is 1 |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
A corrupt cell or security bit stays hidden until a read or verify at that address, so each write scenario is followed right away by a read-back through the port. A write that repeats during a held strobe, or that lands while the device is unqualified, shows at the next read of that address as a byte with too few ones. A missed write or AND shows as a byte with too many. A decode fault shows in the same cycle as a wrong `data_oe_o`, and a skipped erase shows at the first erase verify.

// File: rtl/flash_prog_pkg.sv
`timescale 1ns/1ps
package flash_prog_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW_BUS = 16;

  localparam logic [1:0] VPP_NORM  = 2'b00;
  localparam logic [1:0] VPP_PROG  = 2'b01;
  localparam logic [1:0] VPP_ERASE = 2'b10;

  localparam logic [3:0] SEL_MAIN  = 4'b0000;
  localparam logic [3:0] SEL_ERASE = 4'b0001;

  localparam logic [AW_BUS-1:0] SEC_ADDR = 16'hFFFF;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_ODIS,
    OP_PROG,
    OP_PVFY,
    OP_ERASE,
    OP_EVFY,
    OP_INHIBIT
  } pm_op_e;
endpackage

// File: rtl/flash_pin_decode.sv
`timescale 1ns/1ps
module flash_pin_decode
  import flash_prog_pkg::*;
(
  input  logic          qual_ok_i,
  input  logic [3:0]    ctl_sel_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic [1:0]    vpp_lvl_i,
  input  logic          addr_lsb_i,
  input  logic [DW-1:0] data_i,
  output pm_op_e        op_o
);
  logic erase_ok;
  assign erase_ok = !addr_lsb_i && (data_i == '1);

  always_comb begin
    op_o = OP_NONE;
    if (!qual_ok_i) begin
      op_o = OP_NONE;
    end else if (ce_ni && oe_ni) begin
      op_o = OP_INHIBIT;
    end else begin
      unique case ({ctl_sel_i, vpp_lvl_i, ce_ni, oe_ni})
        {SEL_MAIN,  VPP_NORM,  1'b0, 1'b0}: op_o = OP_READ;
        {SEL_MAIN,  VPP_NORM,  1'b0, 1'b1}: op_o = OP_ODIS;
        {SEL_MAIN,  VPP_PROG,  1'b0, 1'b1}: op_o = OP_PROG;
        {SEL_MAIN,  VPP_PROG,  1'b1, 1'b0}: op_o = OP_PVFY;
        {SEL_ERASE, VPP_ERASE, 1'b0, 1'b1}: op_o = erase_ok ? OP_ERASE : OP_NONE;
        {SEL_ERASE, VPP_ERASE, 1'b1, 1'b0}: op_o = OP_EVFY;
        default:                            op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cell_array.sv
`timescale 1ns/1ps
module flash_cell_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          erase_all_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cell_q <= '1;
      else if (erase_all_i)                        cell_q <= '1;
      else if (wr_en_i && wr_idx_i == AW'(i))      cell_q <= cell_q & wr_data_i;
    end
    assign cells[i] = cell_q;
  end

  assign rd_data_o = cells[rd_idx_i];

  // after an erase every location reads erased, whatever is addressed
  assert_erase_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |=> (rd_data_o == '1));

  // a program without erase can only clear bits of the addressed cell
  assert_prog_no_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !erase_all_i && rd_idx_i == wr_idx_i) |=>
      ((rd_data_o & ~$past(rd_data_o)) == '0 || rd_idx_i != $past(rd_idx_i)));
endmodule

// File: rtl/flash_sec_reg.sv
`timescale 1ns/1ps
module flash_sec_reg #(
  parameter int unsigned SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_en_i,
  input  logic [SEC_W-1:0] clr_data_i,
  input  logic             set_all_i,
  output logic [SEC_W-1:0] sec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sec_o <= '1;
    else if (set_all_i) sec_o <= '1;
    else if (clr_en_i)  sec_o <= sec_o & clr_data_i;
  end

  assert_sec_no_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_all_i |=> ((sec_o & ~$past(sec_o)) == '0));
endmodule

// File: rtl/flash_prog_ctrl.sv
`timescale 1ns/1ps
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int unsigned ARRAY_AW = 8,
  parameter int unsigned SEC_W    = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pm_reset_i,
  input  logic        pm_latch_i,
  input  logic        pm_store_i,
  input  logic [3:0]  ctl_sel_i,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic [1:0]  vpp_lvl_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  data_o,
  output logic        data_oe_o
);
  pm_op_e          op;
  logic            qual_ok;
  logic            ce_q;
  logic            ce_fall;
  logic            prog_go;
  logic            erase_go;
  logic            sec_hit;
  logic [DW-1:0]   arr_rd;
  logic [DW-1:0]   sec_rd;
  logic [SEC_W-1:0] sec_q;

  assign qual_ok = pm_reset_i && !pm_latch_i && pm_store_i;
  assign sec_hit = (addr_i == SEC_ADDR);

  flash_pin_decode u_decode (
    .qual_ok_i  (qual_ok),
    .ctl_sel_i  (ctl_sel_i),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .vpp_lvl_i  (vpp_lvl_i),
    .addr_lsb_i (addr_i[0]),
    .data_i     (data_i),
    .op_o       (op)
  );

  // strobe edge detector: one write per chip-enable fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b1;
    else         ce_q <= ce_ni;
  end

  assign ce_fall  = ce_q && !ce_ni;
  assign prog_go  = ce_fall && (op == OP_PROG);
  assign erase_go = ce_fall && (op == OP_ERASE);

  flash_cell_array #(.AW(ARRAY_AW), .DW(DW)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (prog_go && !sec_hit),
    .wr_idx_i    (addr_i[ARRAY_AW-1:0]),
    .wr_data_i   (data_i),
    .erase_all_i (erase_go),
    .rd_idx_i    (addr_i[ARRAY_AW-1:0]),
    .rd_data_o   (arr_rd)
  );

  flash_sec_reg #(.SEC_W(SEC_W)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (prog_go && sec_hit),
    .clr_data_i (data_i[SEC_W-1:0]),
    .set_all_i  (erase_go),
    .sec_o      (sec_q)
  );

  always_comb begin
    sec_rd = '1;
    sec_rd[SEC_W-1:0] = sec_q;
  end

  always_comb begin
    data_oe_o = (op == OP_READ) || (op == OP_PVFY) || (op == OP_EVFY);
    data_o    = '0;
    if (data_oe_o) data_o = sec_hit ? sec_rd : arr_rd;
  end

  // bus is only driven while the output-enable strobe is low
  assert_drive_needs_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!oe_ni && !(ce_ni && oe_ni)));

  // unqualified pins never reach the protection register
  assert_unqual_sec_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_ok |=> $stable(sec_q));

  // a held strobe never gives a second write
  assert_single_prog_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go |=> !prog_go);

  assert_single_erase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go |=> !erase_go);
endmodule

// File: tb/sim_flash_prog_ctrl.sv
`timescale 1ns/1ps
module sim_flash_prog_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pm_reset = 1'b1, pm_latch = 1'b0, pm_store = 1'b1;
  logic [3:0]  ctl_sel = 4'b0000;
  logic        ce_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  vpp = 2'b00;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flash_prog_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .pm_reset_i(pm_reset), .pm_latch_i(pm_latch), .pm_store_i(pm_store),
    .ctl_sel_i(ctl_sel), .ce_ni(ce_n), .oe_ni(oe_n), .vpp_lvl_i(vpp),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; ctl_sel = 4'b0000; vpp = 2'b00;
  endtask

  // drives read pins and returns the bus state one ns later
  task automatic rd(input logic [15:0] a, input logic [3:0] sel, input logic [1:0] v,
                    input logic c, output logic oe, output logic [7:0] d);
    @(negedge clk);
    ctl_sel = sel; vpp = v; addr = a; ce_n = c; oe_n = 1'b0;
    #1; oe = doe; d = dout;
  endtask

  task automatic expect_byte(input logic [15:0] a, input logic [7:0] exp, input string tag);
    logic oe; logic [7:0] d;
    rd(a, 4'b0000, 2'b00, 1'b0, oe, d);
    chk(int'(oe), 1, tag);
    chk(int'(d), int'(exp), tag);
    idle();
  endtask

  task automatic strobe(input logic [3:0] sel, input logic [1:0] v,
                        input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ctl_sel = sel; vpp = v; addr = a; din = d; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    idle();
  endtask

  task automatic t_reset();
    logic oe; logic [7:0] d;
    #1; chk(int'(doe), 0, "R12 idle bus");
    expect_byte(16'h0000, 8'hFF, "R12 cell erased");
    expect_byte(16'hFFFF, 8'hFF, "R12 security set");
    rd(16'h0003, 4'b0000, 2'b00, 1'b0, oe, d);
    chk(int'(oe), 1, "R2 read drives");
    idle();
  endtask

  task automatic t_program();
    logic oe; logic [7:0] d;
    strobe(4'b0000, 2'b01, 16'h0012, 8'hA5);
    expect_byte(16'h0012, 8'hA5, "R4 program");
    strobe(4'b0000, 2'b01, 16'h0012, 8'h0F);
    expect_byte(16'h0012, 8'h05, "R4 AND semantics");
    expect_byte(16'h0112, 8'h05, "R2 alias");
    rd(16'h0012, 4'b0000, 2'b01, 1'b1, oe, d);
    chk(int'(oe), 1, "R5 pverify oe");
    chk(int'(d), 8'h05, "R5 pverify data");
    idle();
  endtask

  task automatic t_outdis();
    @(negedge clk);
    ctl_sel = 4'b0000; vpp = 2'b00; addr = 16'h0012; ce_n = 1'b0; oe_n = 1'b1;
    #1; chk(int'(doe), 0, "R3 output disable hiZ");
    idle();
    expect_byte(16'h0012, 8'h05, "R3 unchanged");
  endtask

  task automatic t_hold();
    @(negedge clk);
    ctl_sel = 4'b0000; vpp = 2'b01; addr = 16'h0020; din = 8'hF0; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); din = 8'h0F;
    @(negedge clk); addr = 16'h0021;
    @(negedge clk); ce_n = 1'b1;
    idle();
    expect_byte(16'h0020, 8'hF0, "R10 held strobe one write");
    expect_byte(16'h0021, 8'hFF, "R10 held strobe other addr");
    // strobe falls while unqualified, qualifier returns with strobe held
    @(negedge clk);
    pm_store = 1'b0; ctl_sel = 4'b0000; vpp = 2'b01; addr = 16'h0022; din = 8'h00;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); pm_store = 1'b1;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1;
    idle();
    expect_byte(16'h0022, 8'hFF, "R10 late qualify no write");
  endtask

  task automatic t_qualifier();
    @(negedge clk);
    pm_latch = 1'b1; ctl_sel = 4'b0000; vpp = 2'b00; addr = 16'h0012; ce_n = 1'b0; oe_n = 1'b0;
    #1; chk(int'(doe), 0, "R1 latch high hiZ");
    @(negedge clk); pm_latch = 1'b0; pm_reset = 1'b0;
    #1; chk(int'(doe), 0, "R1 reset low hiZ");
    idle();
    strobe(4'b0000, 2'b01, 16'h0030, 8'h00);
    pm_reset = 1'b1;
    expect_byte(16'h0030, 8'hFF, "R1 no write unqualified");
  endtask

  task automatic t_security();
    logic oe; logic [7:0] d;
    strobe(4'b0000, 2'b01, 16'hFFFF, 8'hF5);
    rd(16'hFFFF, 4'b0000, 2'b01, 1'b1, oe, d);
    chk(int'(d), 8'hF5, "R9 sec cleared");
    idle();
    strobe(4'b0000, 2'b01, 16'hFFFF, 8'hFF);
    expect_byte(16'hFFFF, 8'hF5, "R9 sec no raise");
    expect_byte(16'h00FF, 8'hFF, "R9 array not hit");
  endtask

  task automatic t_inhibit();
    @(negedge clk);
    ctl_sel = 4'b0001; vpp = 2'b10; addr = 16'h0012; din = 8'hFF; ce_n = 1'b1; oe_n = 1'b1;
    #1; chk(int'(doe), 0, "R8 inhibit hiZ");
    @(negedge clk); vpp = 2'b01; ctl_sel = 4'b0000; din = 8'h00;
    #1; chk(int'(doe), 0, "R8 inhibit prog level hiZ");
    idle();
    expect_byte(16'h0012, 8'h05, "R8 array unchanged");
    expect_byte(16'hFFFF, 8'hF5, "R8 sec unchanged");
  endtask

  task automatic t_unlisted();
    logic oe; logic [7:0] d;
    strobe(4'b0010, 2'b01, 16'h0040, 8'h00);
    expect_byte(16'h0040, 8'hFF, "R11 bad select no write");
    strobe(4'b0001, 2'b10, 16'h0000, 8'hFE);
    expect_byte(16'h0012, 8'h05, "R11 erase bad data");
    strobe(4'b0001, 2'b10, 16'h0001, 8'hFF);
    expect_byte(16'h0012, 8'h05, "R11 erase odd addr");
    strobe(4'b0000, 2'b11, 16'h0041, 8'h00);
    expect_byte(16'h0041, 8'hFF, "R11 reserved vpp");
    rd(16'h0012, 4'b0000, 2'b01, 1'b0, oe, d);
    chk(int'(oe), 0, "R11 read at prog level hiZ");
    idle();
  endtask

  task automatic t_erase();
    logic oe; logic [7:0] d;
    strobe(4'b0001, 2'b10, 16'h0000, 8'hFF);
    rd(16'h0012, 4'b0001, 2'b10, 1'b1, oe, d);
    chk(int'(oe), 1, "R7 everify oe");
    chk(int'(d), 8'hFF, "R6 cell erased");
    rd(16'hFFFF, 4'b0001, 2'b10, 1'b1, oe, d);
    chk(int'(d), 8'hFF, "R6 sec restored");
    rd(16'h0020, 4'b0001, 2'b10, 1'b1, oe, d);
    chk(int'(d), 8'hFF, "R7 other cell erased");
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_program();
    t_outdis();
    t_hold();
    t_qualifier();
    t_security();
    t_inhibit();
    t_unlisted();
    t_erase();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule